// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block is the clocked shift mode of a small serial port. The port drives a shift clock and one data line and moves one 8-bit byte per transfer. A transfer starts on a one-cycle start request that carries a byte and a direction flag. When sending, the loaded byte goes out on the data line least significant bit first, and the output enable is held high while the transfer runs. When receiving, the output enable stays low, the data line stays at its idle level, and eight samples taken from the serial input form the received byte.

Every bit period lasts 12 oscillator clocks. The shift clock is low for the first 10 clocks and high for the last 2. Outgoing data changes only at the start of a bit period, on the same clock as the falling shift clock edge. Data is therefore stable for 10 clocks before each rising edge and for 2 clocks after it. Incoming data is captured on the rising edge itself. After the eighth bit period the shift clock goes back to idle high and a done flag pulses for one clock.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is 1, the data output is 1, the output enable is 0, done is 0 and the received byte is 0.
- R2: A transfer has exactly 8 shift clock periods. In each period the clock is low for 10 oscillator clocks and then high for 2. The first low clock starts on the clock edge that accepts the start request.
- R3: With dir_tx_i = 1, bit i of the loaded byte (bit 0 first) is on the data output for the whole of the 12-clock period that ends 2 clocks after rising edge i. The data output changes only together with a falling shift clock edge.
- R4: The output enable is 1 from the accepting edge until the end of the last bit period of a send transfer. It is 0 during receive transfers and while idle.
- R5: With dir_tx_i = 0, the serial input is sampled at each rising shift clock edge. The first sample becomes bit 0 of the received byte and the eighth sample becomes bit 7.
- R6: done_o is 1 for exactly one clock, starting 96 clocks after the accepting edge. In that same clock the shift clock is back at 1.
- R7: A start request that arrives while a transfer is active is ignored, together with the byte and direction that come with it. This holds in every cycle of the transfer, including the last clock before done.
- R8: The received byte changes only at the end of a receive transfer. A send transfer leaves it unchanged.
- R9: A start request that is sampled in the clock in which done_o is 1 is accepted, so transfers can run back to back.
- R10: Whenever the output enable is 0, the data output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle transfer request |
| dir_tx_i | input | 1 | 1 = send tx_byte_i, 0 = receive |
| tx_byte_i | input | 8 | Byte loaded on an accepted start |
| sdi_i | input | 1 | Serial input data |
| sclk_o | output | 1 | Shift clock, idles high |
| sdo_o | output | 1 | Serial output data, idles high |
| sdo_oe_o | output | 1 | Output enable for the data line |
| rx_byte_o | output | 8 | Last received byte |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach is whether a receive sample is taken on exactly the right oscillator clock. A data line that holds each bit for the whole period would hide a sampling point that is one clock early or late. The bench therefore drives the inverse of each receive bit for most of the period and presents the true value only in the single clock before the rising edge. It inverts the line again right after that edge. Send transfers also get start pulses with the opposite direction and a different byte, placed in the middle of the transfer and in the clock just before done.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ssp_state_e;

endpackage

// File: rtl/ssp_rst_sync.sv
module ssp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int DATA_W     = 8,
  parameter int BIT_CLKS   = 12,
  parameter int SETUP_CLKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic busy_i,
  output logic sample_o,
  output logic bit_end_o,
  output logic last_o,
  output logic sclk_o
);

  localparam int PH_W = $clog2(BIT_CLKS);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST     = PH_W'(BIT_CLKS - 1);
  localparam logic [PH_W-1:0] PH_PRE_RISE = PH_W'(SETUP_CLKS - 1);
  localparam logic [PH_W-1:0] PH_RISE     = PH_W'(SETUP_CLKS);
  localparam logic [BC_W-1:0] BC_LAST     = BC_W'(DATA_W - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic [BC_W-1:0] bit_q, bit_d;
  logic            sclk_q, sclk_d;

  assign sample_o  = busy_i & (phase_q == PH_PRE_RISE);
  assign bit_end_o = busy_i & (phase_q == PH_LAST);
  assign last_o    = bit_end_o & (bit_q == BC_LAST);

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    sclk_d  = sclk_q;
    if (accept_i) begin
      phase_d = '0;
      bit_d   = '0;
      sclk_d  = 1'b0;
    end else if (busy_i) begin
      if (phase_q == PH_LAST) begin
        phase_d = '0;
        if (bit_q == BC_LAST) begin
          sclk_d = 1'b1;
        end else begin
          bit_d  = bit_q + 1'b1;
          sclk_d = 1'b0;
        end
      end else begin
        phase_d = phase_q + 1'b1;
        if (phase_q == PH_PRE_RISE) begin
          sclk_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;

  // R2
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LAST);

  // R2
  sclk_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (sclk_q == (phase_q >= PH_RISE)));

  // R2
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BC_LAST);

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dir_tx_i,
  input  logic last_i,
  output logic accept_o,
  output logic busy_o,
  output logic dir_tx_o,
  output logic done_o
);

  ssp_state_e state_q, state_d;
  logic       dir_q, dir_d;
  logic       done_q;

  assign accept_o = start_i & (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          dir_d   = dir_tx_i;
        end
      end
      ST_RUN: begin
        if (last_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      done_q  <= last_i;
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign dir_tx_o = dir_q;
  assign done_o   = done_q;

  // R7
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(dir_q));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              busy_i,
  input  logic              dir_tx_i,
  input  logic              sample_i,
  input  logic              bit_end_i,
  input  logic              last_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_byte_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rx_en;

  assign rx_en = last_i & ~dir_tx_i;

  always_comb begin
    sh_d = sh_q;
    if (accept_i) begin
      sh_d = tx_byte_i;
    end else if (busy_i && dir_tx_i && bit_end_i && !last_i) begin
      sh_d = {1'b1, sh_q[DATA_W-1:1]};
    end else if (busy_i && !dir_tx_i && sample_i) begin
      sh_d = {sdi_i, sh_q[DATA_W-1:1]};
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (rx_en) begin
      rx_d = sh_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      rx_q <= '0;
    end else begin
      sh_q <= sh_d;
      rx_q <= rx_d;
    end
  end

  assign sdo_o     = (busy_i & dir_tx_i) ? sh_q[0] : 1'b1;
  assign rx_byte_o = rx_q;

  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && dir_tx_i) |=> $stable(rx_q));

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_W     = 8,
  parameter int BIT_CLKS   = 12,
  parameter int SETUP_CLKS = 10
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              start_i,
  input  logic              dir_tx_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              done_o
);

  logic rst_n;
  logic accept, busy, dir_tx;
  logic sample, bit_end, last;

  ssp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n)
  );

  ssp_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start_i),
    .dir_tx_i(dir_tx_i),
    .last_i  (last),
    .accept_o(accept),
    .busy_o  (busy),
    .dir_tx_o(dir_tx),
    .done_o  (done_o)
  );

  ssp_bit_timer #(
    .DATA_W    (DATA_W),
    .BIT_CLKS  (BIT_CLKS),
    .SETUP_CLKS(SETUP_CLKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .accept_i (accept),
    .busy_i   (busy),
    .sample_o (sample),
    .bit_end_o(bit_end),
    .last_o   (last),
    .sclk_o   (sclk_o)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .accept_i (accept),
    .tx_byte_i(tx_byte_i),
    .busy_i   (busy),
    .dir_tx_i (dir_tx),
    .sample_i (sample),
    .bit_end_i(bit_end),
    .last_i   (last),
    .sdi_i    (sdi_i),
    .sdo_o    (sdo_o),
    .rx_byte_o(rx_byte_o)
  );

  assign sdo_oe_o = busy & dir_tx;

  // R1
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy |-> sclk_o);

  // R10
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sdo_oe_o |-> sdo_o);

  // R3
  sdo_change_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && $past(busy) && dir_tx && !$stable(sdo_o)) |-> $fell(sclk_o));

endmodule

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;

  typedef struct {
    bit         tx;
    logic [7:0] data;
  } item_t;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       start = 1'b0;
  logic       dir_tx = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sdi = 1'b1;
  logic       sclk, sdo, sdo_oe, done;
  logic [7:0] rx_byte;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   t0 = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_shift_port u0 (
    .clk_i    (clk),
    .arst_ni  (arst_n),
    .start_i  (start),
    .dir_tx_i (dir_tx),
    .tx_byte_i(tx_byte),
    .sdi_i    (sdi),
    .sclk_o   (sclk),
    .sdo_o    (sdo),
    .sdo_oe_o (sdo_oe),
    .rx_byte_o(rx_byte),
    .done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Driver: pushes the expected result, then runs the port stimulus.
  task automatic xfer(input bit tx, input logic [7:0] data, input bit quick,
                      input bit poke);
    item_t it;
    it.tx = tx;
    it.data = data;
    q.push_back(it);
    if (!quick) @(negedge clk);
    start = 1'b1;
    dir_tx = tx;
    tx_byte = tx ? data : 8'h00;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    if (!tx) begin
      for (int b = 0; b < 8; b++) begin
        sdi = ~data[b];
        repeat (9) @(negedge clk);
        sdi = data[b];
        @(negedge clk);
        sdi = ~data[b];
        repeat (2) @(negedge clk);
      end
      sdi = 1'b1;
    end else if (poke) begin
      // R7: requests with opposite direction and other byte mid-transfer
      repeat (40) @(negedge clk);
      start = 1'b1; dir_tx = 1'b0; tx_byte = ~data;
      @(negedge clk);
      start = 1'b0;
      repeat (54) @(negedge clk);
      start = 1'b1; dir_tx = 1'b0; tx_byte = 8'h5A;
      @(negedge clk);
      start = 1'b0;
    end else begin
      repeat (96) @(negedge clk);
    end
  endtask

  // Monitor: follows the shift clock and compares results at done.
  logic       prev_sclk = 1'b1;
  int         low_run = 0;
  int         high_run = 0;
  int         rises = 0;
  logic       sdo_at_fall = 1'b1;
  logic       sdo_at_rise = 1'b1;
  logic [7:0] tx_cap = 8'h00;
  logic [7:0] last_rx = 8'h00;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!sclk) begin
        if (prev_sclk) begin
          if (rises > 0 && rises < 8)
            chk(high_run == 2, "R2", "high time", high_run, 2);
          low_run = 0;
          sdo_at_fall = sdo;
        end
        low_run++;
        if (q.size() > 0 && q[0].tx)
          chk(sdo == sdo_at_fall, "R3", "data moved while clock low", sdo, sdo_at_fall);
      end else begin
        if (!prev_sclk) begin
          rises++;
          high_run = 0;
          sdo_at_rise = sdo;
          chk(low_run == 10, "R2", "low time", low_run, 10);
          if (q.size() > 0) begin
            chk(sdo_oe == q[0].tx, "R4", "output enable", sdo_oe, q[0].tx);
            if (q[0].tx) tx_cap[(rises - 1) & 7] = sdo;
            else chk(sdo == 1'b1, "R10", "idle data during receive", sdo, 1);
          end
        end
        high_run++;
        if (rises > 0 && high_run <= 2 && !done)
          chk(sdo == sdo_at_rise, "R3", "hold after rising edge", sdo, sdo_at_rise);
      end
      if (done) begin
        chk(q.size() > 0, "R7", "unexpected done", 0, 1);
        chk(rises == 8, "R2", "rising edges per transfer", rises, 8);
        chk(sclk == 1'b1, "R6", "clock idle at done", sclk, 1);
        chk(cyc - t0 == 96, "R6", "done latency", cyc - t0, 96);
        chk(sdo_oe == 1'b0, "R4", "enable low at done", sdo_oe, 0);
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          if (it.tx) begin
            chk(tx_cap == it.data, "R3", "shifted byte", tx_cap, it.data);
            chk(rx_byte == last_rx, "R8", "rx byte kept over send", rx_byte, last_rx);
          end else begin
            chk(rx_byte == it.data, "R5", "received byte", rx_byte, it.data);
            last_rx = it.data;
          end
        end
        rises = 0;
        tx_cap = 8'h00;
      end
      prev_sclk = sclk;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk(sclk == 1'b1, "R1", "reset sclk", sclk, 1);
    chk(sdo == 1'b1, "R1", "reset sdo", sdo, 1);
    chk(sdo_oe == 1'b0, "R1", "reset enable", sdo_oe, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(rx_byte == 8'h00, "R1", "reset rx byte", rx_byte, 0);
    mon_on = 1'b1;

    xfer(1'b1, 8'hA5, 1'b0, 1'b0);
    xfer(1'b1, 8'h01, 1'b0, 1'b0);
    xfer(1'b1, 8'h80, 1'b1, 1'b0);   // R9 back to back
    xfer(1'b0, 8'h3C, 1'b0, 1'b0);
    xfer(1'b0, 8'hC3, 1'b1, 1'b0);   // R9 receive back to back
    xfer(1'b1, 8'h5A, 1'b0, 1'b1);   // R7 ignored requests
    xfer(1'b0, 8'h96, 1'b1, 1'b0);
    xfer(1'b1, 8'hFF, 1'b0, 1'b0);   // R8 rx byte kept
    xfer(1'b0, 8'h00, 1'b0, 1'b0);
    xfer(1'b1, 8'h00, 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    // R10
    chk(sdo == 1'b1 && sdo_oe == 1'b0, "R10", "idle after traffic", sdo, 1);
    // R8
    chk(rx_byte == 8'h00, "R8", "final rx byte", rx_byte, 0);
    chk(q.size() == 0, "R6", "missing done pulses", q.size(), 0);
    finish_run();
  end

endmodule